// File: doc/BRIEF.md
# PHY Management Register Access Controller

This block lets software reach registers inside external Ethernet PHYs over a two-wire management bus (MDC clock, bidirectional MDIO data). Software programs four 32-bit control words through a small register port, then sets a start bit. The controller turns the request into one or two serial frames and raises a busy flag that stays set until the last frame ends. For a read, it places the returned 16-bit value in the low half of the data word.

Two access styles are supported. In a paged access, the controller first writes the page number to PHY register 31. It then reads or writes the target register (0 to 31). In an extended (MMD) access, the controller sends an address frame that carries the device number and a 16-bit register address. A read or write frame on the same device follows.

The control word holds a page-parking field that software owns. The controller never alters that field or any other bit of the control word, except the start/busy bit.

Top module: `smi_phy_access`

## Requirements
- R1: After reset all four control words read as zero, MDC is low and the MDIO output enable is low.
- R2: Register port map: address 0 is the 32-bit port mask; address 1 is the command word; address 2 holds write data / read port in bits 31:16 and read-only read result in bits 15:0; address 3 holds the MMD device in bits 20:16 and the MMD register address in bits 15:0, with bits 31:21 reading as zero.
- R3: Command word layout: bit 0 start/busy, bit 1 MMD mode, bit 2 write (1) or read (0), bits 14:3 page, bits 24:20 register number. Writing bit 0 as 1 starts a command. Busy reads 1 until the final frame completes. Completion clears only bit 0, so the parking bits 19:15 and every other bit keep their value.
- R4: A paged write sends two 22-style frames (start 01, write opcode 01, turnaround 10) to the PHY address given by the lowest set bit of the port mask. The first writes the page to register 31. The second writes data bits 31:16 to the selected register.
- R5: A paged read sends the page-select write, then a read frame (opcode 10) to the PHY address in data-word bits 20:16. The result lands in data-word bits 15:0, and bits 31:16 are left unchanged.
- R6: An MMD write sends an address frame (start 00, opcode 00, data = register address), then a write frame (opcode 01, data = data-word bits 31:16). Both frames go to the lowest-set-bit PHY address and the device from address 3.
- R7: An MMD read sends the address frame, then a read frame with opcode 11, and stores the 16 returned bits in data-word bits 15:0.
- R8: During the turnaround and the 16 data bits of any read frame, the MDIO output enable is low. If no PHY drives the line (pull-up high), the read result is 0xFFFF.
- R9: Bus writes to any register while busy have no effect.
- R10: Every frame starts with 32 one-bits. MDC period is 2*MDC_HALF system clocks. MDIO output changes only at MDC falling edges.
- R11: When not busy the MDIO output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write enable for the access |
| bus_addr_i | input | 2 | Register index 0..3 |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data of the addressed register (combinational) |
| mdc_o | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO line value |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |

## Verification
The assertions watch several properties on every cycle. Busy cannot drop before the sequencer reports the end of a command. No bit of the command word other than busy moves while a command runs. The port mask ignores writes during busy. The output enable is low whenever the controller is idle. MDIO never changes while MDC is high.

Only the bench scenarios can show the frame contents. These include the page-select frame to register 31, the lowest-set-bit port choice, the opcodes of the two MMD frames, and the released turnaround on reads. The scenarios also show where returned data lands, and the 0xFFFF result when no responder answers.

// File: rtl/smi_pkg.sv
package smi_pkg;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_F1, SEQ_F2} seq_state_e;

  localparam logic [1:0] A_PMASK = 2'd0;
  localparam logic [1:0] A_CMD   = 2'd1;
  localparam logic [1:0] A_DATA  = 2'd2;
  localparam logic [1:0] A_MMD   = 2'd3;

  // 22-style frame body (after preamble)
  function automatic logic [31:0] c22_word(input logic rd, input logic [4:0] phy,
                                           input logic [4:0] ra, input logic [15:0] d);
    return {2'b01, (rd ? 2'b10 : 2'b01), phy, ra, 2'b10, d};
  endfunction

  // 45-style frame body (after preamble)
  function automatic logic [31:0] c45_word(input logic [1:0] op, input logic [4:0] phy,
                                           input logic [4:0] dev, input logic [15:0] d);
    return {2'b00, op, phy, dev, 2'b10, d};
  endfunction

  function automatic logic [4:0] lowest_set(input logic [31:0] m);
    logic [4:0] r;
    r = '0;
    for (int i = 31; i >= 0; i--) begin
      if (m[i]) r = 5'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/smi_mdc_gen.sv
module smi_mdc_gen #(
  parameter int MDC_HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;
  localparam logic [CW-1:0] TOP = CW'(MDC_HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (cnt_q == TOP) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mdc_o  = mdc_q;
  assign rise_o = (cnt_q == TOP) && !mdc_q;
  assign fall_o = (cnt_q == TOP) && mdc_q;
endmodule

// File: rtl/smi_frame_eng.sv
module smi_frame_eng #(
  parameter int PRE_LEN = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rise_i,
  input  logic        fall_i,
  input  logic        go_i,
  input  logic [31:0] word_i,
  input  logic        rd_i,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  output logic        done_o,
  output logic [15:0] rdata_o
);
  localparam int FL = PRE_LEN + 32;
  localparam int CW = $clog2(FL);
  localparam logic [CW-1:0] REL  = CW'(PRE_LEN + 14);
  localparam logic [CW-1:0] DAT  = CW'(PRE_LEN + 16);
  localparam logic [CW-1:0] LAST = CW'(FL - 1);

  logic [FL-1:0] frame_q;
  logic [CW-1:0] cnt_q;
  logic [14:0]   sh_q;
  logic          active_q, drove_q, rd_q, mdio_q, oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q  <= '1;
      cnt_q    <= '0;
      sh_q     <= '0;
      active_q <= 1'b0;
      drove_q  <= 1'b0;
      rd_q     <= 1'b0;
      mdio_q   <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      if (active_q && fall_i) begin
        mdio_q  <= frame_q[FL-1];
        frame_q <= {frame_q[FL-2:0], 1'b1};
        oe_q    <= !(rd_q && cnt_q >= REL);
        drove_q <= 1'b1;
      end
      if (active_q && drove_q && rise_i) begin
        if (rd_q && cnt_q >= DAT) sh_q <= {sh_q[13:0], mdio_i};
        if (cnt_q == LAST) begin
          active_q <= 1'b0;
          oe_q     <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (go_i) begin
        active_q <= 1'b1;
        drove_q  <= 1'b0;
        cnt_q    <= '0;
        frame_q  <= {{PRE_LEN{1'b1}}, word_i};
        rd_q     <= rd_i;
      end
    end
  end

  assign done_o    = active_q && drove_q && rise_i && (cnt_q == LAST);
  assign rdata_o   = {sh_q, mdio_i};  // valid together with done_o
  assign mdio_o    = mdio_q;
  assign mdio_oe_o = oe_q;
endmodule

// File: rtl/smi_seq.sv
module smi_seq
  import smi_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        mmd_i,
  input  logic        wr_i,
  input  logic [4:0]  reg_i,
  input  logic [11:0] page_i,
  input  logic [31:0] pmask_i,
  input  logic [4:0]  rd_port_i,
  input  logic [15:0] wdata_i,
  input  logic [4:0]  dev_i,
  input  logic [15:0] maddr_i,
  input  logic        eng_done_i,
  input  logic [15:0] eng_rdata_i,
  output logic        eng_go_o,
  output logic [31:0] eng_word_o,
  output logic        eng_rd_o,
  output logic        done_o,
  output logic        rd_valid_o,
  output logic [15:0] rd_data_o
);
  seq_state_e  state_q;
  logic [31:0] f2_q;
  logic        rd_q;
  logic [4:0]  port;
  logic [31:0] f1, f2;
  logic [15:0] dfield;

  always_comb begin
    port   = (mmd_i || wr_i) ? lowest_set(pmask_i) : rd_port_i;
    dfield = wr_i ? wdata_i : 16'hFFFF;
    if (mmd_i) begin
      f1 = c45_word(2'b00, port, dev_i, maddr_i);
      f2 = c45_word(wr_i ? 2'b01 : 2'b11, port, dev_i, dfield);
    end else begin
      f1 = c22_word(1'b0, port, 5'd31, {4'b0, page_i});
      f2 = c22_word(!wr_i, port, reg_i, dfield);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      f2_q    <= '0;
      rd_q    <= 1'b0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (start_i) begin
          state_q <= SEQ_F1;
          f2_q    <= f2;
          rd_q    <= !wr_i;
        end
        SEQ_F1: if (eng_done_i) state_q <= SEQ_F2;
        SEQ_F2: if (eng_done_i) state_q <= SEQ_IDLE;
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign eng_go_o   = (state_q == SEQ_IDLE && start_i) || (state_q == SEQ_F1 && eng_done_i);
  assign eng_word_o = (state_q == SEQ_IDLE) ? f1 : f2_q;
  assign eng_rd_o   = (state_q != SEQ_IDLE) && rd_q;
  assign done_o     = (state_q == SEQ_F2) && eng_done_i;
  assign rd_valid_o = done_o && rd_q;
  assign rd_data_o  = eng_rdata_i;
endmodule

// File: rtl/smi_regs.sv
module smi_regs
  import smi_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sel_i,
  input  logic        we_i,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wdata_i,
  input  logic        done_i,
  input  logic        rd_valid_i,
  input  logic [15:0] rd_data_i,
  output logic [31:0] ctrl0_o,
  output logic [31:0] ctrl1_o,
  output logic [31:0] ctrl2_o,
  output logic [20:0] ctrl3_o,
  output logic        start_o,
  output logic [31:0] rdata_o
);
  logic [31:0] c0_q, c1_q;
  logic [15:0] c2_hi_q, c2_lo_q;
  logic [20:0] c3_q;
  logic        start_q;
  logic        wr_ok;

  assign wr_ok = sel_i && we_i && !c1_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c0_q <= '0; c1_q <= '0; c2_hi_q <= '0; c2_lo_q <= '0; c3_q <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (wr_ok) begin
        unique case (addr_i)
          A_PMASK: c0_q <= wdata_i;
          A_CMD: begin
            c1_q    <= wdata_i;
            start_q <= wdata_i[0];
          end
          A_DATA:  c2_hi_q <= wdata_i[31:16];
          A_MMD:   c3_q <= wdata_i[20:0];
          default: ;
        endcase
      end
      if (done_i)     c1_q[0] <= 1'b0;
      if (rd_valid_i) c2_lo_q <= rd_data_i;
    end
  end

  always_comb begin
    unique case (addr_i)
      A_PMASK: rdata_o = c0_q;
      A_CMD:   rdata_o = c1_q;
      A_DATA:  rdata_o = {c2_hi_q, c2_lo_q};
      default: rdata_o = {11'b0, c3_q};
    endcase
  end

  assign ctrl0_o = c0_q;
  assign ctrl1_o = c1_q;
  assign ctrl2_o = {c2_hi_q, c2_lo_q};
  assign ctrl3_o = c3_q;
  assign start_o = start_q;
endmodule

// File: rtl/smi_phy_access.sv
module smi_phy_access #(
  parameter int MDC_HALF = 4,
  parameter int PRE_LEN  = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_sel_i,
  input  logic        bus_we_i,
  input  logic [1:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        mdc_o,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe_o
);
  logic [31:0] ctrl0_q, ctrl1_q, ctrl2_q;
  logic [20:0] ctrl3_q;
  logic        start, seq_done, rd_valid;
  logic [15:0] rd_data, eng_rdata;
  logic        rise, fall, eng_go, eng_rd, eng_done;
  logic [31:0] eng_word;

  smi_regs u_regs (
    .clk_i, .rst_ni,
    .sel_i(bus_sel_i), .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .done_i(seq_done), .rd_valid_i(rd_valid), .rd_data_i(rd_data),
    .ctrl0_o(ctrl0_q), .ctrl1_o(ctrl1_q), .ctrl2_o(ctrl2_q), .ctrl3_o(ctrl3_q),
    .start_o(start), .rdata_o(bus_rdata_o)
  );

  smi_seq u_seq (
    .clk_i, .rst_ni,
    .start_i(start), .mmd_i(ctrl1_q[1]), .wr_i(ctrl1_q[2]),
    .reg_i(ctrl1_q[24:20]), .page_i(ctrl1_q[14:3]),
    .pmask_i(ctrl0_q), .rd_port_i(ctrl2_q[20:16]), .wdata_i(ctrl2_q[31:16]),
    .dev_i(ctrl3_q[20:16]), .maddr_i(ctrl3_q[15:0]),
    .eng_done_i(eng_done), .eng_rdata_i(eng_rdata),
    .eng_go_o(eng_go), .eng_word_o(eng_word), .eng_rd_o(eng_rd),
    .done_o(seq_done), .rd_valid_o(rd_valid), .rd_data_o(rd_data)
  );

  smi_mdc_gen #(.MDC_HALF(MDC_HALF)) u_mdc (
    .clk_i, .rst_ni, .mdc_o(mdc_o), .rise_o(rise), .fall_o(fall)
  );

  smi_frame_eng #(.PRE_LEN(PRE_LEN)) u_eng (
    .clk_i, .rst_ni, .rise_i(rise), .fall_i(fall),
    .go_i(eng_go), .word_i(eng_word), .rd_i(eng_rd), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .done_o(eng_done), .rdata_o(eng_rdata)
  );
endmodule

// File: rtl/smi_phy_access_chk.sv
module smi_phy_access_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] ctrl0_i,
  input logic [31:0] ctrl1_i,
  input logic        seq_done_i,
  input logic        bus_wr_i,
  input logic        mdc_i,
  input logic        mdio_i,
  input logic        mdio_oe_i
);
  p_busy_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl1_i[0] && !seq_done_i |=> ctrl1_i[0]);

  p_cmd_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl1_i[0] |=> ctrl1_i[31:1] == $past(ctrl1_i[31:1]));

  p_ign_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl1_i[0] && bus_wr_i |=> $stable(ctrl0_i));

  p_idle_release_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl1_i[0] |-> !mdio_oe_i);

  p_mdio_steady_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdc_i && $past(mdc_i) |-> $stable(mdio_i));
endmodule

bind smi_phy_access smi_phy_access_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .ctrl0_i(ctrl0_q), .ctrl1_i(ctrl1_q),
  .seq_done_i(seq_done), .bus_wr_i(bus_sel_i & bus_we_i),
  .mdc_i(mdc_o), .mdio_i(mdio_o), .mdio_oe_i(mdio_oe_o)
);

// File: tb/smi_phy_access_tb_top.sv
`timescale 1ns/1ps
module smi_phy_access_tb_top;
  localparam int HALF = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_sel_i = 1'b0, bus_we_i = 1'b0;
  logic [1:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        mdc_o, mdio_o, mdio_oe_o, mdio_line;
  logic        resp_en = 1'b0, resp_drv = 1'b0, resp_bit = 1'b1;
  logic [15:0] resp_data = '0;
  logic        last_line = 1'b1, last_oe = 1'b0;
  int          n_checks = 0, n_errors = 0;
  logic [31:0] exp_q[$];

  always #2.5 clk_i = ~clk_i;

  assign mdio_line = mdio_oe_o ? mdio_o : (resp_drv ? resp_bit : 1'b1);

  smi_phy_access dut_i (
    .clk_i, .rst_ni, .bus_sel_i, .bus_we_i, .bus_addr_i, .bus_wdata_i, .bus_rdata_o,
    .mdc_o, .mdio_i(mdio_line), .mdio_o, .mdio_oe_o
  );

  always @(negedge clk_i) begin
    last_line = mdio_line;
    last_oe   = mdio_oe_o;
  end

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] w22(input logic rd, input logic [4:0] phy, input logic [4:0] ra,
                                      input logic [15:0] d);
    return {2'b01, rd ? 2'b10 : 2'b01, phy, ra, 2'b10, d};
  endfunction
  function automatic logic [31:0] w45(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] dev,
                                      input logic [15:0] d);
    return {2'b00, op, phy, dev, 2'b10, d};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    bus_sel_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_sel_i = 1'b0; bus_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk_i);
    bus_sel_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = a;
    #1 d = bus_rdata_o;
    bus_sel_i = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    do rd(2'd1, v); while (v[0]);
    chk(exp_q.size() == 0, "R4 all frames seen", 64'(exp_q.size()), 64'd0);
    chk(!mdio_oe_o, "R11 idle release", 64'(mdio_oe_o), 64'd0);
  endtask

  // monitor / responder
  initial begin
    forever begin
      @(negedge clk_i);
      if (mdio_oe_o) begin
        logic [63:0] fr;
        logic        rd_fr, oe_ok;
        logic [31:0] e;
        fr = '0; rd_fr = 1'b0; oe_ok = 1'b1;
        for (int k = 0; k < 64; k++) begin
          if (k >= 47 && rd_fr && resp_en) begin
            @(negedge mdc_o);
            resp_drv = 1'b1;
            resp_bit = (k == 47) ? 1'b0 : resp_data[63-k];
          end
          @(posedge mdc_o);
          fr[63-k] = last_line;
          if (rd_fr && k >= 46 && last_oe) oe_ok = 1'b0;
          if (k == 45)
            rd_fr = (fr[31:28] == 4'b0110) || (fr[31:28] == 4'b0011);
        end
        resp_drv = 1'b0;
        if (rd_fr) chk(oe_ok, "R8 released during read", 64'(!oe_ok), 64'd0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4 unexpected frame", fr, 64'd0);
        end else begin
          e = exp_q.pop_front();
          chk(fr == {32'hFFFF_FFFF, e}, "R10 R4 R5 R6 R7 frame content", fr, {32'hFFFF_FFFF, e});
        end
        while (mdio_oe_o) @(negedge clk_i);
      end
    end
  end

  initial begin
    #2_000_000;
    chk(1'b0, "watchdog", 64'd0, 64'd1);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [31:0] v, cmd;
    realtime t0, t1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk(v == 0, "R1 reset register", 64'(v), 64'd0);
    end
    chk(!mdio_oe_o, "R1 oe low", 64'(mdio_oe_o), 64'd0);
    // R10 MDC period
    @(posedge mdc_o); t0 = $realtime;
    @(posedge mdc_o); t1 = $realtime;
    chk((t1 - t0) == 2 * HALF * 5.0, "R10 mdc period", 64'(int'(t1 - t0)), 64'(2 * HALF * 5));
    // R2 map
    wr(2'd0, 32'h0000_0220);
    wr(2'd3, 32'hFFFA_BEEF);
    wr(2'd2, 32'h5A5A_1234);
    rd(2'd0, v); chk(v == 32'h0000_0220, "R2 port mask", 64'(v), 64'h220);
    rd(2'd3, v); chk(v == 32'h001A_BEEF, "R2 mmd word", 64'(v), 64'h001A_BEEF);
    rd(2'd2, v); chk(v == 32'h5A5A_0000, "R2 data low read-only", 64'(v), 64'h5A5A_0000);
    // R4 paged write to port 5, page 0x123, reg 9, park bits 0x15
    cmd = (32'd9 << 20) | (32'h15 << 15) | (32'h123 << 3) | 32'h4 | 32'h1;
    exp_q.push_back(w22(1'b0, 5'd5, 5'd31, 16'h0123));
    exp_q.push_back(w22(1'b0, 5'd5, 5'd9, 16'h5A5A));
    wr(2'd1, cmd);
    rd(2'd1, v); chk(v[0], "R3 busy after start", 64'(v), 64'(cmd));
    // R9 writes while busy
    wr(2'd0, 32'hFFFF_FFFF);
    wr(2'd2, 32'h0000_0000);
    wr(2'd1, 32'h0000_0000);
    rd(2'd1, v); chk(v == cmd, "R9 command write ignored", 64'(v), 64'(cmd));
    wait_idle();
    rd(2'd1, v); chk(v == (cmd & ~32'h1), "R3 only busy cleared", 64'(v), 64'(cmd & ~32'h1));
    rd(2'd0, v); chk(v == 32'h0000_0220, "R9 mask unchanged", 64'(v), 64'h220);
    rd(2'd2, v); chk(v[31:16] == 16'h5A5A, "R9 data unchanged", 64'(v), 64'h5A5A_0000);
    // R5 paged read port 7 reg 2 page 0xA5
    wr(2'd2, 32'h0007_0000);
    resp_en = 1'b1; resp_data = 16'h1234;
    cmd = (32'd2 << 20) | (32'h0A5 << 3) | 32'h1;
    exp_q.push_back(w22(1'b0, 5'd7, 5'd31, 16'h00A5));
    exp_q.push_back(w22(1'b1, 5'd7, 5'd2, 16'h1234));
    wr(2'd1, cmd);
    wait_idle();
    rd(2'd2, v); chk(v == 32'h0007_1234, "R5 read result", 64'(v), 64'h0007_1234);
    // R6 MMD write port 3 dev 7 addr 0x3C
    wr(2'd0, 32'h0000_0008);
    wr(2'd3, 32'h0007_003C);
    wr(2'd2, 32'hBEEF_0000);
    exp_q.push_back(w45(2'b00, 5'd3, 5'd7, 16'h003C));
    exp_q.push_back(w45(2'b01, 5'd3, 5'd7, 16'hBEEF));
    wr(2'd1, 32'h7);
    wait_idle();
    rd(2'd2, v); chk(v == 32'hBEEF_1234, "R6 data word after write", 64'(v), 64'hBEEF_1234);
    // R7 MMD read port 17 dev 31 addr 0x8001
    wr(2'd0, 32'h0002_0000);
    wr(2'd3, 32'h001F_8001);
    resp_data = 16'hC0DE;
    exp_q.push_back(w45(2'b00, 5'd17, 5'd31, 16'h8001));
    exp_q.push_back(w45(2'b11, 5'd17, 5'd31, 16'hC0DE));
    wr(2'd1, 32'h3);
    wait_idle();
    rd(2'd2, v); chk(v[15:0] == 16'hC0DE, "R7 mmd read result", 64'(v), 64'hC0DE);
    // R8 no responder
    resp_en = 1'b0;
    wr(2'd2, 32'h001E_0000);
    exp_q.push_back(w22(1'b0, 5'd30, 5'd31, 16'h0001));
    exp_q.push_back({w22(1'b1, 5'd30, 5'd4, 16'hFFFF)} | 32'h0001_0000);
    wr(2'd1, (32'd4 << 20) | (32'h1 << 3) | 32'h1);
    wait_idle();
    rd(2'd2, v); chk(v[15:0] == 16'hFFFF, "R8 idle line reads ones", 64'(v), 64'hFFFF);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule